// File: doc/BRIEF.md
# I2C Master Write Transfer-End Sequencer

This block decides how an I2C master write ends. Software gives it a target address, a byte count and a frame option, then pulses a start request. The block has the byte-level bit engine generate a START, send the address byte with the write direction bit, and send the programmed number of data bytes. When the count reaches zero, the end policy chosen by the frame option sets the next step. The block can generate a STOP on its own. It can park the bus and wait for software to ask for a STOP or a repeated START. It can also raise a reload flag and wait for a fresh count, then carry on with the same address phase.

The block sits between a register-style control port and the bit engine. It sends one-cycle strobes to the engine: START, repeated START, STOP and "send this byte". The engine answers with a condition-done pulse, or with a byte-done pulse that carries the ACK/NACK bit. A NACK on any byte ends the transfer early with a STOP, and a sticky flag records it.

Top module: `i2c_xfer_end`

## Requirements
- R1: With the auto-end policy, once the count is used up the block issues a STOP strobe in the cycle after the exhaustion check, without any software request, and then returns to idle.
- R2: With the software-end policy, once the count is used up the block raises `tc_o`, issues no STOP, and stays busy. A later `stop_req_i` pulse issues a STOP in the next cycle.
- R3: With the reload policy, once the count is used up the block raises `reload_o` and stalls. A `count_wr_i` pulse loads `count_i` and a new policy from `frame_opt_i`. The transfer then continues with no new START and no new address byte.
- R4: `frame_opt_i` selects the policy as follows. Codes 0 (first) and 5 (last, no stop) select software-end. Codes 1 (first and next) and 2 (next) select reload. Codes 3 (single complete), 4 (last), 6 and 7 select auto-end.
- R5: While held under software-end, with no STOP or repeated-START request, `tc_o` and `busy_o` stay high and no STOP strobe appears, however long the wait lasts.
- R6: A NACK on the address byte or on any data byte ends the transfer with a STOP, whatever the policy. It sets `nack_o`, which stays high until the next accepted start.
- R7: A count of zero sends only the address byte, and the end policy then acts at once.
- R8: A `rstart_req_i` pulse while held issues a repeated-START strobe with no STOP before it. It then sends a new address byte and the newly loaded `count_i` data bytes.
- R9: The first byte after a START is `{addr_i, 1'b0}` (bits 7:1 address, bit 0 write = 0). Each data byte equals `data_i` at the time it is sent, and exactly `count` data bytes are sent (count 0 to 255).
- R10: After reset the block is idle, with `busy_o`, `tc_o`, `reload_o`, `nack_o` and every engine strobe low.
- R11: A `start_i` pulse while the block is busy has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse, accepted only when idle |
| frame_opt_i | input | 3 | Frame option code, sampled on start, repeated start and count reload |
| count_i | input | 8 | Data byte count, sampled with frame_opt_i |
| addr_i | input | 7 | Target address, sampled on start and repeated start |
| data_i | input | 8 | Data byte presented with each data send strobe |
| count_wr_i | input | 1 | New count pulse, used while reload_o is high |
| stop_req_i | input | 1 | STOP request pulse, used while tc_o is high |
| rstart_req_i | input | 1 | Repeated-START request pulse, used while tc_o is high |
| eng_start_o | output | 1 | Engine strobe: generate START |
| eng_rstart_o | output | 1 | Engine strobe: generate repeated START |
| eng_stop_o | output | 1 | Engine strobe: generate STOP |
| eng_byte_go_o | output | 1 | Engine strobe: shift out eng_byte_o |
| eng_byte_o | output | 8 | Byte for the engine to send |
| eng_cond_done_i | input | 1 | Engine finished a START/STOP condition |
| eng_byte_done_i | input | 1 | Engine finished a byte, with the ACK bit sampled |
| eng_nack_i | input | 1 | Valid with eng_byte_done_i: the byte was not acknowledged |
| busy_o | output | 1 | A transfer owns the bus |
| tc_o | output | 1 | Count used up under software-end, bus held |
| reload_o | output | 1 | Count used up under reload, waiting for a new count |
| nack_o | output | 1 | Sticky: the last transfer was aborted by a NACK |

## Verification
The assertions assume the engine behaves: it sends a condition-done or byte-done pulse only after the matching strobe, never two at once, and it drives the NACK bit only together with byte-done. They also assume the request pulses last one cycle and that software gives stop and repeated-START requests only while `tc_o` is high. The bench's engine model answers each strobe once, after a fixed delay of two or three cycles. All control pulses are one cycle wide and driven between clock edges. Requests outside their state are used only to show that they are ignored.

// File: rtl/i2cend_pkg.sv
package i2cend_pkg;

  typedef enum logic [1:0] {
    POL_AUTO   = 2'd0,
    POL_SOFT   = 2'd1,
    POL_RELOAD = 2'd2
  } policy_e;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_GEN_START  = 4'd1,
    ST_GEN_RSTART = 4'd2,
    ST_WAIT_COND  = 4'd3,
    ST_SEND_ADDR  = 4'd4,
    ST_WAIT_ADDR  = 4'd5,
    ST_CHECK      = 4'd6,
    ST_SEND_DATA  = 4'd7,
    ST_WAIT_DATA  = 4'd8,
    ST_RELOAD     = 4'd9,
    ST_HELD       = 4'd10,
    ST_ABORT      = 4'd11,
    ST_GEN_STOP   = 4'd12,
    ST_WAIT_STOP  = 4'd13
  } state_e;

  localparam logic [2:0] FO_FIRST      = 3'd0;
  localparam logic [2:0] FO_FIRST_NEXT = 3'd1;
  localparam logic [2:0] FO_NEXT       = 3'd2;
  localparam logic [2:0] FO_SINGLE     = 3'd3;
  localparam logic [2:0] FO_LAST       = 3'd4;
  localparam logic [2:0] FO_LAST_HOLD  = 3'd5;

  // Frame option to end policy; unlisted codes fall back to auto-end.
  function automatic policy_e frame_policy(input logic [2:0] code);
    case (code)
      FO_FIRST, FO_LAST_HOLD: return POL_SOFT;
      FO_FIRST_NEXT, FO_NEXT: return POL_RELOAD;
      default:                return POL_AUTO;
    endcase
  endfunction

  // Address byte of a write: address in the upper bits, direction bit zero.
  function automatic logic [7:0] write_addr_byte(input logic [6:0] addr);
    return {addr, 1'b0};
  endfunction

endpackage

// File: rtl/i2cend_mode_dec.sv
module i2cend_mode_dec
  import i2cend_pkg::*;
(
  input  logic [2:0] frame_opt_i,
  output policy_e    policy_o
);
  always_comb policy_o = frame_policy(frame_opt_i);
endmodule

// File: rtl/i2cend_byte_cnt.sv
module i2cend_byte_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2cend_seq.sv
module i2cend_seq
  import i2cend_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              count_wr_i,
  input  logic              stop_req_i,
  input  logic              rstart_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  policy_e           policy_in_i,
  input  logic              cnt_zero_i,
  input  logic              eng_cond_done_i,
  input  logic              eng_byte_done_i,
  input  logic              eng_nack_i,
  output logic              cnt_load_o,
  output logic              cnt_dec_o,
  output logic              eng_start_o,
  output logic              eng_rstart_o,
  output logic              eng_stop_o,
  output logic              eng_byte_go_o,
  output logic [DATA_W-1:0] eng_byte_o,
  output logic              busy_o,
  output logic              tc_o,
  output logic              reload_o,
  output logic              nack_o,
  output state_e            state_o,
  output policy_e           policy_o,
  output logic              byte_wait_o,
  output logic              exhaust_o
);
  state_e            state_q, state_d;
  policy_e           policy_q;
  logic [ADDR_W-1:0] addr_q;
  logic              nack_q;
  logic              take_start, take_rstart, take_reload, abort_ev;

  assign take_start  = (state_q == ST_IDLE) && start_i;
  assign take_rstart = (state_q == ST_HELD) && !stop_req_i && rstart_req_i;
  assign take_reload = (state_q == ST_RELOAD) && count_wr_i;
  assign byte_wait_o = (state_q == ST_WAIT_ADDR) || (state_q == ST_WAIT_DATA);
  assign abort_ev    = byte_wait_o && eng_byte_done_i && eng_nack_i;
  assign exhaust_o   = (state_q == ST_CHECK) && cnt_zero_i;

  assign cnt_load_o  = take_start || take_rstart || take_reload;
  assign cnt_dec_o   = (state_q == ST_WAIT_DATA) && eng_byte_done_i && !eng_nack_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start_i) state_d = ST_GEN_START;
      ST_GEN_START:  state_d = ST_WAIT_COND;
      ST_GEN_RSTART: state_d = ST_WAIT_COND;
      ST_WAIT_COND:  if (eng_cond_done_i) state_d = ST_SEND_ADDR;
      ST_SEND_ADDR:  state_d = ST_WAIT_ADDR;
      ST_WAIT_ADDR,
      ST_WAIT_DATA:  if (eng_byte_done_i) state_d = eng_nack_i ? ST_ABORT : ST_CHECK;
      ST_CHECK: begin
        if (!cnt_zero_i) state_d = ST_SEND_DATA;
        else begin
          case (policy_q)
            POL_SOFT:   state_d = ST_HELD;
            POL_RELOAD: state_d = ST_RELOAD;
            default:    state_d = ST_GEN_STOP;
          endcase
        end
      end
      ST_SEND_DATA:  state_d = ST_WAIT_DATA;
      ST_RELOAD:     if (count_wr_i) state_d = ST_CHECK;
      ST_HELD: begin
        if (stop_req_i)        state_d = ST_GEN_STOP;
        else if (rstart_req_i) state_d = ST_GEN_RSTART;
      end
      ST_ABORT:      state_d = ST_GEN_STOP;
      ST_GEN_STOP:   state_d = ST_WAIT_STOP;
      ST_WAIT_STOP:  if (eng_cond_done_i) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      policy_q <= POL_AUTO;
      addr_q   <= '0;
      nack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_load_o) policy_q <= policy_in_i;
      if (take_start || take_rstart) addr_q <= addr_i;
      if (take_start)    nack_q <= 1'b0;
      else if (abort_ev) nack_q <= 1'b1;
    end
  end

  assign eng_start_o   = (state_q == ST_GEN_START);
  assign eng_rstart_o  = (state_q == ST_GEN_RSTART);
  assign eng_stop_o    = (state_q == ST_GEN_STOP);
  assign eng_byte_go_o = (state_q == ST_SEND_ADDR) || (state_q == ST_SEND_DATA);

  always_comb begin
    case (state_q)
      ST_SEND_ADDR: eng_byte_o = write_addr_byte(addr_q);
      ST_SEND_DATA: eng_byte_o = data_i;
      default:      eng_byte_o = '0;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign tc_o     = (state_q == ST_HELD);
  assign reload_o = (state_q == ST_RELOAD);
  assign nack_o   = nack_q;
  assign state_o  = state_q;
  assign policy_o = policy_q;
endmodule

// File: rtl/i2c_xfer_end.sv
module i2c_xfer_end
  import i2cend_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8,
  parameter int DATA_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        frame_opt_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              count_wr_i,
  input  logic              stop_req_i,
  input  logic              rstart_req_i,
  output logic              eng_start_o,
  output logic              eng_rstart_o,
  output logic              eng_stop_o,
  output logic              eng_byte_go_o,
  output logic [DATA_W-1:0] eng_byte_o,
  input  logic              eng_cond_done_i,
  input  logic              eng_byte_done_i,
  input  logic              eng_nack_i,
  output logic              busy_o,
  output logic              tc_o,
  output logic              reload_o,
  output logic              nack_o
);
  // Named internal events, brought out for the bound checker.
  policy_e dec_policy_w;
  policy_e policy_w;
  state_e  state_w;
  logic    cnt_zero_w, cnt_load_w, cnt_dec_w;
  logic    byte_wait_w, exhaust_w;

  i2cend_mode_dec u_dec (
    .frame_opt_i (frame_opt_i),
    .policy_o    (dec_policy_w)
  );

  i2cend_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load_w),
    .load_val_i (count_i),
    .dec_i      (cnt_dec_w),
    .zero_o     (cnt_zero_w)
  );

  i2cend_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .count_wr_i      (count_wr_i),
    .stop_req_i      (stop_req_i),
    .rstart_req_i    (rstart_req_i),
    .addr_i          (addr_i),
    .data_i          (data_i),
    .policy_in_i     (dec_policy_w),
    .cnt_zero_i      (cnt_zero_w),
    .eng_cond_done_i (eng_cond_done_i),
    .eng_byte_done_i (eng_byte_done_i),
    .eng_nack_i      (eng_nack_i),
    .cnt_load_o      (cnt_load_w),
    .cnt_dec_o       (cnt_dec_w),
    .eng_start_o     (eng_start_o),
    .eng_rstart_o    (eng_rstart_o),
    .eng_stop_o      (eng_stop_o),
    .eng_byte_go_o   (eng_byte_go_o),
    .eng_byte_o      (eng_byte_o),
    .busy_o          (busy_o),
    .tc_o            (tc_o),
    .reload_o        (reload_o),
    .nack_o          (nack_o),
    .state_o         (state_w),
    .policy_o        (policy_w),
    .byte_wait_o     (byte_wait_w),
    .exhaust_o       (exhaust_w)
  );
endmodule

// File: rtl/i2cend_chk.sv
module i2cend_chk
  import i2cend_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    stop_req_i,
  input logic    rstart_req_i,
  input logic    count_wr_i,
  input logic    eng_start_o,
  input logic    eng_rstart_o,
  input logic    eng_stop_o,
  input logic    eng_byte_go_o,
  input logic    eng_byte_done_i,
  input logic    eng_nack_i,
  input logic    busy_o,
  input logic    tc_o,
  input logic    reload_o,
  input logic    nack_o,
  input policy_e policy_w,
  input logic    byte_wait_w,
  input logic    exhaust_w
);
  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_w && policy_w == POL_AUTO |=> eng_stop_o); // R1

  AST_SOFT_STOP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o && stop_req_i |=> eng_stop_o && !tc_o); // R2

  AST_RELOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o && !count_wr_i |=> reload_o); // R3

  AST_RELOAD_NO_COND: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |=> !eng_start_o && !eng_rstart_o && !eng_stop_o); // R3

  AST_HOLD_FOREVER: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o && !stop_req_i && !rstart_req_i |=> tc_o && busy_o && !eng_stop_o); // R5

  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wait_w && eng_byte_done_i && eng_nack_i |=> ##1 eng_stop_o); // R6

  AST_NACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_o) |=> eng_stop_o); // R6

  AST_RSTART_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o && !stop_req_i && rstart_req_i |=> eng_rstart_o && !eng_stop_o); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start_o, eng_rstart_o, eng_stop_o, eng_byte_go_o})); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !eng_byte_go_o && !eng_stop_o && !tc_o && !reload_o); // R10

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tc_o && reload_o)); // R3
endmodule

bind i2c_xfer_end i2cend_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .stop_req_i      (stop_req_i),
  .rstart_req_i    (rstart_req_i),
  .count_wr_i      (count_wr_i),
  .eng_start_o     (eng_start_o),
  .eng_rstart_o    (eng_rstart_o),
  .eng_stop_o      (eng_stop_o),
  .eng_byte_go_o   (eng_byte_go_o),
  .eng_byte_done_i (eng_byte_done_i),
  .eng_nack_i      (eng_nack_i),
  .busy_o          (busy_o),
  .tc_o            (tc_o),
  .reload_o        (reload_o),
  .nack_o          (nack_o),
  .policy_w        (policy_w),
  .byte_wait_w     (byte_wait_w),
  .exhaust_w       (exhaust_w)
);

// File: tb/test_i2c_xfer_end.sv
`timescale 1ns/1ps
module test_i2c_xfer_end;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, count_wr_i = 0, stop_req_i = 0, rstart_req_i = 0;
  logic [2:0] frame_opt_i = 0;
  logic [7:0] count_i = 0, data_i = 8'h5A;
  logic [6:0] addr_i = 7'h31;
  logic       eng_start_o, eng_rstart_o, eng_stop_o, eng_byte_go_o;
  logic [7:0] eng_byte_o;
  logic       eng_cond_done_i = 0, eng_byte_done_i = 0, eng_nack_i = 0;
  logic       busy_o, tc_o, reload_o, nack_o;

  always #2 clk = ~clk;

  i2c_xfer_end i_i2c_xfer_end (.*);

  // Engine model state and observed traffic.
  int n_start, n_rstart, n_stop, n_addr, n_data, n_bad;
  int idx, cur_idx, cd, nack_at;
  bit kind_byte;
  logic [7:0] exp_addr;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_start = 0; n_rstart = 0; n_stop = 0; n_addr = 0; n_data = 0; n_bad = 0;
  endtask

  // Byte engine model: answers each strobe after a fixed delay.
  initial begin
    cd = 0; idx = 0; cur_idx = 0; kind_byte = 0; nack_at = -1;
    clear_counts();
    forever begin
      @(negedge clk);
      eng_cond_done_i = 0; eng_byte_done_i = 0; eng_nack_i = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          if (kind_byte) begin
            eng_byte_done_i = 1;
            eng_nack_i = (cur_idx == nack_at);
          end else eng_cond_done_i = 1;
        end
      end
      if (rst_n) begin
        if (eng_start_o)  begin n_start++;  idx = 0; kind_byte = 0; cd = 2; end
        if (eng_rstart_o) begin n_rstart++; idx = 0; kind_byte = 0; cd = 2; end
        if (eng_stop_o)   begin n_stop++;   kind_byte = 0; cd = 2; end
        if (eng_byte_go_o) begin
          cur_idx = idx;
          if (idx == 0) begin n_addr++; if (eng_byte_o != exp_addr) n_bad++; end
          else begin n_data++; if (eng_byte_o != data_i) n_bad++; end
          idx++; kind_byte = 1; cd = 3;
        end
      end
    end
  end

  task automatic settle();
    int t = 0;
    do begin @(negedge clk); t++; end
    while (busy_o && !tc_o && !reload_o && t < 5000);
    chk(t < 5000, "settle timeout", t, 5000);
  endtask

  task automatic pulse_start(input logic [2:0] opt, input logic [7:0] cnt);
    @(negedge clk);
    frame_opt_i = opt; count_i = cnt; exp_addr = {addr_i, 1'b0}; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic release_bus();
    if (tc_o) begin
      stop_req_i = 1; @(negedge clk); stop_req_i = 0;
    end else if (reload_o) begin
      frame_opt_i = 3'd4; count_i = 0; count_wr_i = 1; @(negedge clk); count_wr_i = 0;
    end
    settle();
  endtask

  typedef struct packed {
    logic [2:0] opt;
    logic [7:0] cnt;
    logic [7:0] nak;    // 8'hFF: no NACK
    logic [7:0] xdata;
    logic [1:0] xstop;
    logic       xtc;
    logic       xrl;
    logic       xnk;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 8'd3,   8'hFF, 8'd3,   2'd1, 1'b0, 1'b0, 1'b0}, // R1 single
    '{3'd4, 8'd1,   8'hFF, 8'd1,   2'd1, 1'b0, 1'b0, 1'b0}, // R4 last
    '{3'd6, 8'd2,   8'hFF, 8'd2,   2'd1, 1'b0, 1'b0, 1'b0}, // R4 spare code
    '{3'd0, 8'd2,   8'hFF, 8'd2,   2'd0, 1'b1, 1'b0, 1'b0}, // R2 first
    '{3'd5, 8'd1,   8'hFF, 8'd1,   2'd0, 1'b1, 1'b0, 1'b0}, // R4 last hold
    '{3'd1, 8'd2,   8'hFF, 8'd2,   2'd0, 1'b0, 1'b1, 1'b0}, // R3 first+next
    '{3'd2, 8'd1,   8'hFF, 8'd1,   2'd0, 1'b0, 1'b1, 1'b0}, // R4 next
    '{3'd3, 8'd0,   8'hFF, 8'd0,   2'd1, 1'b0, 1'b0, 1'b0}, // R7 zero, auto
    '{3'd0, 8'd0,   8'hFF, 8'd0,   2'd0, 1'b1, 1'b0, 1'b0}, // R7 zero, soft
    '{3'd3, 8'd3,   8'd0,  8'd0,   2'd1, 1'b0, 1'b0, 1'b1}, // R6 address NACK
    '{3'd0, 8'd4,   8'd2,  8'd2,   2'd1, 1'b0, 1'b0, 1'b1}, // R6 data NACK, soft
    '{3'd1, 8'd3,   8'd3,  8'd3,   2'd1, 1'b0, 1'b0, 1'b1}, // R6 data NACK, reload
    '{3'd3, 8'd255, 8'hFF, 8'd255, 2'd1, 1'b0, 1'b0, 1'b0}  // R9 full count
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !tc_o && !reload_o && !nack_o, "R10 flags", {busy_o, tc_o, reload_o, nack_o}, 0);
    chk(!eng_start_o && !eng_rstart_o && !eng_stop_o && !eng_byte_go_o, "R10 strobes",
        {eng_start_o, eng_rstart_o, eng_stop_o, eng_byte_go_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_counts();
      nack_at = (VECS[v].nak == 8'hFF) ? -1 : int'(VECS[v].nak);
      pulse_start(VECS[v].opt, VECS[v].cnt);
      settle();
      chk(n_data == VECS[v].xdata, "R9/R7 data bytes", n_data, VECS[v].xdata);
      chk(n_stop == VECS[v].xstop, "R1/R2/R6 stops", n_stop, VECS[v].xstop);
      chk(tc_o == VECS[v].xtc, "R2/R4 tc", tc_o, VECS[v].xtc);
      chk(reload_o == VECS[v].xrl, "R3/R4 reload", reload_o, VECS[v].xrl);
      chk(nack_o == VECS[v].xnk, "R6 nack flag", nack_o, VECS[v].xnk);
      chk(n_addr == 1 && n_bad == 0 && n_start == 1, "R9 byte content", n_bad, 0);
      release_bus();
      nack_at = -1;
    end

    // R6 flag clears on the next accepted start
    clear_counts();
    nack_at = 0;
    pulse_start(3'd3, 8'd1);
    settle();
    chk(nack_o == 1, "R6 set", nack_o, 1);
    nack_at = -1;
    pulse_start(3'd3, 8'd1);
    chk(nack_o == 0, "R6 cleared", nack_o, 0);
    settle();

    // R5 and R11: held bus stays held; a start while busy is ignored
    clear_counts();
    pulse_start(3'd0, 8'd1);
    settle();
    start_i = 1; count_i = 8'd9; frame_opt_i = 3'd3; @(negedge clk); start_i = 0;
    repeat (500) @(negedge clk);
    chk(tc_o && busy_o, "R5 still held", {tc_o, busy_o}, 3);
    chk(n_stop == 0 && n_start == 1, "R11 start ignored", n_start, 1);
    chk(n_data == 1, "R11 no extra bytes", n_data, 1);
    stop_req_i = 1; @(negedge clk); stop_req_i = 0;
    chk(eng_stop_o == 1, "R2 stop after request", eng_stop_o, 1);
    settle();
    chk(!busy_o && n_stop == 1, "R2 released", n_stop, 1);

    // R3: reload continues the same address phase
    clear_counts();
    pulse_start(3'd1, 8'd2);
    settle();
    chk(reload_o == 1, "R3 reload raised", reload_o, 1);
    repeat (20) @(negedge clk);
    chk(reload_o && n_data == 2, "R3 stalled", n_data, 2);
    frame_opt_i = 3'd4; count_i = 8'd3; count_wr_i = 1; @(negedge clk); count_wr_i = 0;
    settle();
    chk(n_data == 5, "R3 continued bytes", n_data, 5);
    chk(n_start == 1 && n_addr == 1 && n_rstart == 0, "R3 no new address", n_addr, 1);
    chk(n_stop == 1 && !busy_o, "R3 auto end after reload", n_stop, 1);

    // R8: repeated start from held state
    clear_counts();
    pulse_start(3'd0, 8'd1);
    settle();
    addr_i = 7'h4C; exp_addr = {7'h4C, 1'b0};
    frame_opt_i = 3'd3; count_i = 8'd2; rstart_req_i = 1;
    @(negedge clk); rstart_req_i = 0;
    chk(eng_rstart_o == 1 && eng_stop_o == 0, "R8 rstart strobe", eng_rstart_o, 1);
    settle();
    chk(n_rstart == 1 && n_addr == 2, "R8 new address phase", n_addr, 2);
    chk(n_data == 3 && n_bad == 0, "R8 bytes", n_data, 3);
    chk(n_stop == 1, "R8 single stop", n_stop, 1);

    // R7: zero count reload stays at reload until a count arrives
    clear_counts();
    pulse_start(3'd2, 8'd0);
    settle();
    chk(reload_o && n_data == 0 && n_addr == 1, "R7 zero reload", n_data, 0);
    release_bus();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule